// File: doc/BRIEF.md
# Configurable MCU Port Controller

This block owns a bank of general-purpose pin ports that a microcontroller configures through a small synchronous register bus. Every pin is set up on its own. A direction bit decides whether the pin drives or listens. A drive-strength bit is held and passed to pad logic outside the block. On the upper ports, a mode bit lets the pin forward one bit of an internal address bus instead of the value the MCU wrote. The ports are not all the same width, and not all of them have a mode register.

Each port has a data-out register, a direction register, a drive register and, on the upper ports only, a mode register. These registers drive the flat pad output, output-enable and drive vectors. Pad inputs pass through a two-flop synchronizer before the MCU reads them back. Bus address bits [7:4] select the register kind and bits [3:0] select the port. Read data is registered and appears in the cycle after the read strobe.

Top module: `port_ctrl`

## Requirements
- R1: After reset every data-out, direction, mode and drive register is 0. `pad_oe_o`, `pad_out_o`, `drive_o` and `rdata_o` are all 0.
- R2: A write at address {kind, port} stores `wdata_i` on the clock edge that samples `wr_i`. Kind codes are 1 data-out, 2 direction, 3 mode, 4 drive. A read loads `rdata_o` on the edge that samples `rd_i`, and `rdata_o` holds its value while no read is strobed.
- R3: In MCU mode a pin's output enable equals its direction bit (1 = output), and its pad output equals its data-out bit.
- R4: Ports 4, 5 and 6 have a mode register. A mode bit of 1 makes the pin drive the matching bit of `iaddr_i`, using byte 0, 1 or 2 for port 4, 5 or 6, and forces its output enable to 1 whatever the direction bit holds.
- R5: Ports 0 to 3 have no mode register. Writes to their mode address are ignored, reads of it return 0, and their pins stay in MCU mode.
- R6: Port 3 has 4 pins. The upper four bits of its registers ignore writes and read as 0. In the flat pin vectors, port p starts at bit 8*p for p ≤ 3 and at bit 28+8*(p-4) for p ≥ 4, for 52 pins in total.
- R7: A read of kind 0 returns the port's pad levels after a two-flop synchronizer. A read strobed in the same cycle that a pad changes returns the old level, and a read strobed three cycles later returns the new one. Writes to kind 0 are ignored.
- R8: `drive_o` mirrors the drive registers, and the drive registers have no effect on `pad_out_o` or `pad_oe_o`.
- R9: A read of an unmapped address (kind above 4 or port above 6) returns 0. A write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address: [7:4] kind, [3:0] port |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| iaddr_i | input | 24 | Internal address bits forwarded by pins in address mode |
| pad_in_i | input | 52 | Pad input levels, all ports packed |
| pad_out_o | output | 52 | Pad output values |
| pad_oe_o | output | 52 | Pad output enables |
| drive_o | output | 52 | Drive-select bit per pin, passed to pad logic |

## Verification
A table of writes and read-backs covers every register kind on a full-width port, on the narrow port and on a port without a mode register. This separates stored bits from masked bits and from absent registers. Pin outputs are then checked with mixed mode and direction bits on one port, with data-out and internal-address patterns chosen so that each output bit reveals which source drove it. A second internal-address pattern confirms that the address-mode pins follow the input live. Pad-input reads strobed in the same cycle as a change and again later separate the synchronizer latency from missing synchronization. Drive and unmapped-address accesses are compared against snapshots of the pin outputs so that any side effect shows up.

// File: rtl/port_ctrl_pkg.sv
package port_ctrl_pkg;

  typedef enum logic [3:0] {
    K_PIN  = 4'd0,
    K_DOUT = 4'd1,
    K_DIR  = 4'd2,
    K_MODE = 4'd3,
    K_DRV  = 4'd4
  } reg_kind_e;

  function automatic int port_width(int p, int full_w, int narrow_idx, int narrow_w);
    return (p == narrow_idx) ? narrow_w : full_w;
  endfunction

  function automatic int port_offset(int p, int full_w, int narrow_idx, int narrow_w);
    int s;
    s = 0;
    for (int i = 0; i < p; i++) s += port_width(i, full_w, narrow_idx, narrow_w);
    return s;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  assign sync_o = s2_q;

  // cycles since reset, saturating
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
  end

  a_r7_two_stage: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd2) |-> (sync_o == $past(pin_i, 2)));

endmodule

// File: rtl/port_cfg.sv
module port_cfg #(
  parameter int WIDTH    = 8,
  parameter bit HAS_MODE = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_dout_i,
  input  logic             wr_dir_i,
  input  logic             wr_mode_i,
  input  logic             wr_drv_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] addr_bits_i,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] pin_sync_o,
  output logic [WIDTH-1:0] dout_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] mode_o,
  output logic [WIDTH-1:0] drv_o,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);

  logic [WIDTH-1:0] dout_q, dir_q, mode_q, drv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
      mode_q <= '0;
      drv_q  <= '0;
    end else begin
      if (wr_dout_i)             dout_q <= wdata_i;
      if (wr_dir_i)              dir_q  <= wdata_i;
      if (wr_mode_i && HAS_MODE) mode_q <= wdata_i; // stays 0 on ports without mode
      if (wr_drv_i)              drv_q  <= wdata_i;
    end
  end

  pin_sync #(.WIDTH(WIDTH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .sync_o(pin_sync_o)
  );

  // address mode overrides both data and direction per pin
  always_comb begin
    for (int b = 0; b < WIDTH; b++) begin
      pad_out_o[b] = mode_q[b] ? addr_bits_i[b] : dout_q[b];
      pad_oe_o[b]  = mode_q[b] | dir_q[b];
    end
  end

  assign dout_o = dout_q;
  assign dir_o  = dir_q;
  assign mode_o = mode_q;
  assign drv_o  = drv_q;

  a_r2_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir_i |=> (dir_q == $past(wdata_i)));

  a_r2_dout_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dout_i |=> (dout_q == $past(wdata_i)));

  a_r5_mode_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mode_i && !HAS_MODE) |=> $stable(mode_q));

  a_r8_drv_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_drv_i && !wr_dout_i && !wr_dir_i && !wr_mode_i) |=> $stable(pad_oe_o));

endmodule

// File: rtl/port_ctrl.sv
module port_ctrl
  import port_ctrl_pkg::*;
#(
  parameter int NUM_PORTS  = 7,
  parameter int PORT_W     = 8,
  parameter int MODE_BASE  = 4,
  parameter int NARROW_IDX = 3,
  parameter int NARROW_W   = 4,
  parameter int ADDR_W     = 8,
  localparam int KIND_W    = 4,
  localparam int SEL_W     = ADDR_W - KIND_W,
  localparam int TOTAL     = port_offset(NUM_PORTS, PORT_W, NARROW_IDX, NARROW_W),
  localparam int IADDR_W   = (NUM_PORTS - MODE_BASE) * PORT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [PORT_W-1:0]  wdata_i,
  input  logic               wr_i,
  input  logic               rd_i,
  output logic [PORT_W-1:0]  rdata_o,
  input  logic [IADDR_W-1:0] iaddr_i,
  input  logic [TOTAL-1:0]   pad_in_i,
  output logic [TOTAL-1:0]   pad_out_o,
  output logic [TOTAL-1:0]   pad_oe_o,
  output logic [TOTAL-1:0]   drive_o
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NUM_PORTS - 1);

  logic [KIND_W-1:0] kind;
  logic [SEL_W-1:0]  sel;
  assign kind = addr_i[ADDR_W-1 -: KIND_W];
  assign sel  = addr_i[SEL_W-1:0];

  logic [PORT_W-1:0] rd_port [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam int  W        = port_width(p, PORT_W, NARROW_IDX, NARROW_W);
    localparam int  OFF      = port_offset(p, PORT_W, NARROW_IDX, NARROW_W);
    localparam bit  HAS_MODE = (p >= MODE_BASE);

    logic         hit;
    logic [W-1:0] addr_bits, pin_sync, dout, dir, mode, drv;

    assign hit = (sel == SEL_W'(p));

    if (HAS_MODE) begin : g_addr
      assign addr_bits = iaddr_i[(p - MODE_BASE) * PORT_W +: W];
    end else begin : g_noaddr
      assign addr_bits = '0;
    end

    port_cfg #(.WIDTH(W), .HAS_MODE(HAS_MODE)) i_cfg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_dout_i  (wr_i && hit && (kind == K_DOUT)),
      .wr_dir_i   (wr_i && hit && (kind == K_DIR)),
      .wr_mode_i  (wr_i && hit && (kind == K_MODE)),
      .wr_drv_i   (wr_i && hit && (kind == K_DRV)),
      .wdata_i    (wdata_i[W-1:0]),
      .addr_bits_i(addr_bits),
      .pin_i      (pad_in_i[OFF +: W]),
      .pin_sync_o (pin_sync),
      .dout_o     (dout),
      .dir_o      (dir),
      .mode_o     (mode),
      .drv_o      (drv),
      .pad_out_o  (pad_out_o[OFF +: W]),
      .pad_oe_o   (pad_oe_o[OFF +: W])
    );

    assign drive_o[OFF +: W] = drv;

    always_comb begin
      rd_port[p] = '0;
      case (kind)
        K_PIN:   rd_port[p][W-1:0] = pin_sync;
        K_DOUT:  rd_port[p][W-1:0] = dout;
        K_DIR:   rd_port[p][W-1:0] = dir;
        K_MODE:  rd_port[p][W-1:0] = mode;
        K_DRV:   rd_port[p][W-1:0] = drv;
        default: rd_port[p] = '0;
      endcase
    end
  end

  logic [PORT_W-1:0] rdata_d, rdata_q;

  always_comb begin
    rdata_d = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel == SEL_W'(p)) rdata_d = rd_port[p];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

  a_r9_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && ((kind > K_DRV) || (sel > LAST_SEL))) |=> (rdata_o == '0));

  a_r2_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  if (NARROW_W < PORT_W) begin : g_narrow_chk
    a_r6_narrow_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && (sel == SEL_W'(NARROW_IDX))) |=> (rdata_o[PORT_W-1:NARROW_W] == '0));
  end

endmodule

// File: tb/test_port_ctrl.sv
module test_port_ctrl;

  localparam int TOTAL   = 52;
  localparam int IADDR_W = 24;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic [7:0]         addr_i = '0;
  logic [7:0]         wdata_i = '0;
  logic               wr_i = 1'b0;
  logic               rd_i = 1'b0;
  logic [7:0]         rdata_o;
  logic [IADDR_W-1:0] iaddr_i = '0;
  logic [TOTAL-1:0]   pad_in_i = '0;
  logic [TOTAL-1:0]   pad_out_o, pad_oe_o, drive_o;

  always #2 clk = ~clk;

  port_ctrl i_port_ctrl (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .rdata_o  (rdata_o),
    .iaddr_i  (iaddr_i),
    .pad_in_i (pad_in_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o),
    .drive_o  (drive_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // {kind, port, wdata, expected readback, unused}
  localparam logic [31:0] VEC [10] = '{
    {4'd1, 4'd0, 8'hA5, 8'hA5, 8'h00},
    {4'd2, 4'd1, 8'h3C, 8'h3C, 8'h00},
    {4'd4, 4'd2, 8'hF0, 8'hF0, 8'h00},
    {4'd1, 4'd3, 8'hFF, 8'h0F, 8'h00},
    {4'd2, 4'd3, 8'hAB, 8'h0B, 8'h00},
    {4'd3, 4'd0, 8'hFF, 8'h00, 8'h00},
    {4'd3, 4'd4, 8'h81, 8'h81, 8'h00},
    {4'd3, 4'd6, 8'hFF, 8'hFF, 8'h00},
    {4'd4, 4'd6, 8'h5A, 8'h5A, 8'h00},
    {4'd2, 4'd5, 8'h07, 8'h07, 8'h00}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]       rd;
    logic [TOTAL-1:0] snap_out, snap_oe;

    do_reset();

    // R2 table: write then read back each vector
    for (int i = 0; i < 10; i++) begin
      do_write(VEC[i][31:24], VEC[i][23:16]);
      do_read(VEC[i][31:24], rd);
      check($sformatf("R2 vector %0d readback", i), 64'(rd), 64'(VEC[i][15:8]));
    end

    // R1 reset state
    do_reset();
    @(negedge clk);
    check("R1 pad_oe after reset", 64'(pad_oe_o), 64'(0));
    check("R1 pad_out after reset", 64'(pad_out_o), 64'(0));
    check("R1 drive after reset", 64'(drive_o), 64'(0));
    check("R1 rdata after reset", 64'(rdata_o), 64'(0));
    do_read(8'h46, rd);
    check("R1 drive port6 cleared", 64'(rd), 64'(0));

    iaddr_i = 24'h123456;

    // R3 MCU mode
    do_write(8'h10, 8'h96);
    do_write(8'h20, 8'h0F);
    @(negedge clk);
    check("R3 port0 pad_out", 64'(pad_out_o[7:0]), 64'h96);
    check("R3 port0 pad_oe", 64'(pad_oe_o[7:0]), 64'h0F);

    // R5 mode write ignored on port 0
    do_write(8'h30, 8'hFF);
    do_read(8'h30, rd);
    check("R5 port0 mode reads 0", 64'(rd), 64'(0));
    check("R5 port0 pad_out unchanged", 64'(pad_out_o[7:0]), 64'h96);
    check("R5 port0 pad_oe unchanged", 64'(pad_oe_o[7:0]), 64'h0F);

    // R4 address mode on port 4 (offset 28)
    do_write(8'h14, 8'hAA);
    do_write(8'h24, 8'h03);
    do_write(8'h34, 8'hF0);
    @(negedge clk);
    check("R4 port4 mixed pad_out", 64'(pad_out_o[35:28]), 64'h5A);
    check("R4 port4 mixed pad_oe", 64'(pad_oe_o[35:28]), 64'hF3);
    check("R4 port6 idle pad_out", 64'(pad_out_o[51:44]), 64'h00);
    iaddr_i = 24'h1234A5;
    @(negedge clk);
    check("R4 port4 follows iaddr", 64'(pad_out_o[35:28]), 64'hAA);

    // R6 narrow port 3 (offset 24, 4 pins)
    do_write(8'h23, 8'hFF);
    @(negedge clk);
    check("R6 port3 pad_oe", 64'(pad_oe_o[27:24]), 64'hF);
    check("R6 port4 pad_oe untouched", 64'(pad_oe_o[35:28]), 64'hF3);
    do_read(8'h23, rd);
    check("R6 port3 dir upper bits 0", 64'(rd), 64'h0F);

    // R7 synchronized pin read on port 5 (offset 36)
    @(negedge clk);
    pad_in_i[43:36] = 8'hC3;
    addr_i = 8'h05; rd_i = 1'b1;
    @(negedge clk);
    rd_i = 1'b0;
    check("R7 same-cycle read old level", 64'(rdata_o), 64'h00);
    repeat (2) @(negedge clk);
    do_read(8'h05, rd);
    check("R7 read after sync", 64'(rd), 64'hC3);
    do_write(8'h05, 8'h00);
    do_read(8'h05, rd);
    check("R7 pin kind write ignored", 64'(rd), 64'hC3);

    // R8 drive select
    snap_out = pad_out_o;
    snap_oe  = pad_oe_o;
    do_write(8'h40, 8'hFF);
    @(negedge clk);
    check("R8 drive port0", 64'(drive_o[7:0]), 64'hFF);
    check("R8 pad_out unaffected", 64'(pad_out_o), 64'(snap_out));
    check("R8 pad_oe unaffected", 64'(pad_oe_o), 64'(snap_oe));
    do_read(8'h40, rd);
    check("R8 drive readback", 64'(rd), 64'hFF);

    // R2 read data holds without strobe
    repeat (3) @(negedge clk);
    check("R2 rdata holds", 64'(rdata_o), 64'hFF);

    // R9 unmapped
    do_read(8'h70, rd);
    check("R9 unmapped kind reads 0", 64'(rd), 64'h00);
    do_read(8'h19, rd);
    check("R9 unmapped port reads 0", 64'(rd), 64'h00);
    snap_out = pad_out_o;
    snap_oe  = pad_oe_o;
    do_write(8'h19, 8'h55);
    do_write(8'h29, 8'h55);
    do_write(8'h70, 8'h55);
    @(negedge clk);
    check("R9 unmapped write pad_out", 64'(pad_out_o), 64'(snap_out));
    check("R9 unmapped write pad_oe", 64'(pad_oe_o), 64'(snap_oe));
    do_read(8'h10, rd);
    check("R9 port0 dout intact", 64'(rd), 64'h96);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule